// File: doc/BRIEF.md
# DMA Descriptor Chain Sequencer

This block steps a DMA channel through a linked list of descriptors that sit in memory. Each descriptor is four 32-bit words: a link to the next descriptor (word 0), a source address (word 1), a destination address (word 2) and a byte count (word 3). The sequencer reads each descriptor through a simple request/response read port and hands the transfer fields to a separate transfer engine. It then waits for the engine's completion pulse and follows the link. A link of zero ends the chain.

Software can extend a chain at any time without stopping the channel. It patches the link word of the last descriptor and then sets a resume bit through the control write port. The sequencer checks the resume bit at two points: when the chain has run out, and while the unit is idle. If the bit is set, the sequencer fetches the link word of the descriptor it last handled a second time. It does not rely on the pointer it cached earlier. If the re-read link is non-zero, the walk continues from there.

The block keeps two address registers. The current-descriptor register holds the address of the descriptor being handled. The next-descriptor register holds the link that will be followed next. The current address is kept after the chain ends, so that a later resume can find the tail again.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset, `busy` is 0, `cur_addr` is 0, and `mem_req`, `eng_start` and `chain_done` are all low.
- R2: A start write while idle clears the low four bits of `cfg_first_addr` and uses the result as the descriptor address. The block then reads the words at that address +0, +4, +8 and +12, in that order. Only one read is outstanding at a time. Each `mem_req` lasts one cycle and occurs only while `busy` is 1.
- R3: After the fourth word returns, `eng_start` pulses for one cycle. At that point `eng_src`, `eng_dst` and `eng_len` carry words 1, 2 and 3, and `cur_addr` equals the descriptor address. The three engine fields stay stable until `eng_done`.
- R4: When `eng_done` arrives and the link word (with its low four bits cleared) is non-zero, the descriptor at that link is fetched next.
- R5: When `eng_done` arrives with a zero link and the resume bit clear, the unit goes idle. `chain_done` pulses for exactly one cycle, in the first idle cycle. `cur_addr` keeps the address of the last descriptor.
- R6: If resume was written before a chain's last descriptor completes, the block makes a single read of word 0 at `cur_addr`. If that link is non-zero, the walk continues from it.
- R7: A resume write while idle causes a single read of word 0 at `cur_addr`. If that link is non-zero, a new descriptor is fetched and run. If it is zero, the unit returns to idle with a `chain_done` pulse.
- R8: The resume bit is cleared when a descriptor completes with a non-zero link. A resume written during a non-final descriptor therefore causes no extra read at the end of the chain.
- R9: A start write while `busy` is 1 has no effect on the reads issued or on the descriptors run.
- R10: A start write whose aligned address is zero issues no read and runs no descriptor. It gives one `chain_done` pulse and leaves `cur_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_start | input | 1 | Start bit of the control write |
| cfg_resume | input | 1 | Resume bit of the control write |
| cfg_first_addr | input | 32 | First descriptor address for a start |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| eng_start | output | 1 | One-cycle pulse: transfer fields valid, engine may start |
| eng_src | output | 32 | Source address of the current transfer |
| eng_dst | output | 32 | Destination address of the current transfer |
| eng_len | output | 32 | Byte count of the current transfer |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| busy | output | 1 | Unit is walking a chain or re-reading a link |
| cur_addr | output | 32 | Current-descriptor address |
| chain_done | output | 1 | One-cycle pulse when the unit returns to idle |

## Verification
Most internal faults in this sequencer show up at the memory port within a few cycles. A stale next-descriptor pointer, or a resume bit that is not cleared, produces a read address that is out of order or not expected at all. Such a read appears as soon as the following descriptor completes, or on the first idle cycle after a resume. A wrong state transition either drops `chain_done` when `busy` falls or gives an `eng_start` whose fields do not match the memory image. The bench walks its own copy of the descriptor memory to predict every read address and every transfer, then compares them at the clock on which they occur.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int DESC_WORDS = 4;
    localparam int LINK_IDX   = 0;
    localparam int SRC_IDX    = 1;
    localparam int DST_IDX    = 2;
    localparam int LEN_IDX    = 3;
    localparam int WORD_SH    = $clog2(DATA_W / 8);
    localparam int ALIGN_BITS = $clog2(DESC_WORDS) + WORD_SH;
    localparam int CNT_W      = $clog2(DESC_WORDS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FETCH,
        ST_RUN,
        ST_RELINK
    } seq_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] dst;
        logic [DATA_W-1:0] len;
    } xfer_t;

    typedef logic [DESC_WORDS-1:0][DATA_W-1:0] desc_words_t;

    function automatic logic [ADDR_W-1:0] align_desc(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    endfunction

endpackage

// File: rtl/dcs_fetch.sv
module dcs_fetch
    import dcs_pkg::*;
#(
    parameter int NW = DESC_WORDS,
    parameter int CW = $clog2(NW + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     go,
    input  logic [ADDR_W-1:0]        base,
    input  logic [CW-1:0]            nwords,
    output logic                     mem_req,
    output logic [ADDR_W-1:0]        mem_addr,
    input  logic                     mem_rvalid,
    input  logic [DATA_W-1:0]        mem_rdata,
    output logic [NW-1:0][DATA_W-1:0] words,
    output logic                     done
);
    localparam int IW = (NW > 1) ? $clog2(NW) : 1;

    logic              active;
    logic              pending;
    logic [IW-1:0]     idx;
    logic [IW-1:0]     last;
    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            pending <= 1'b0;
            idx     <= '0;
            last    <= '0;
            base_q  <= '0;
            words   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                active  <= 1'b1;
                pending <= 1'b0;
                idx     <= '0;
                last    <= IW'(nwords - CW'(1));
                base_q  <= base;
            end else if (active) begin
                if (mem_req) begin
                    pending <= 1'b1;
                end
                if (pending && mem_rvalid) begin
                    words[idx] <= mem_rdata;
                    pending    <= 1'b0;
                    idx        <= idx + 1'b1;
                    if (idx == last) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end
            end
        end
    end

    assign mem_req  = active & ~pending;
    assign mem_addr = base_q + (ADDR_W'(idx) << WORD_SH);

endmodule

// File: rtl/dcs_ctrl.sv
module dcs_ctrl
    import dcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_start,
    input  logic              cfg_resume,
    input  logic [ADDR_W-1:0] cfg_first_addr,
    output logic              fetch_go,
    output logic [ADDR_W-1:0] fetch_base,
    output logic [CNT_W-1:0]  fetch_nwords,
    input  logic              fetch_done,
    input  desc_words_t       fetch_words,
    output logic              eng_start,
    output xfer_t             xfer,
    input  logic              eng_done,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              chain_done
);
    seq_state_t        st;
    logic [ADDR_W-1:0] cda;
    logic [ADDR_W-1:0] nda;
    logic              resume_q;
    logic              resume_clr;
    logic              start_wr;

    assign start_wr = cfg_we & cfg_start;

    always_comb begin
        resume_clr = 1'b0;
        if (st == ST_IDLE && !start_wr && resume_q) begin
            resume_clr = 1'b1;
        end
        if (st == ST_RUN && eng_done) begin
            resume_clr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resume_q <= 1'b0;
        end else begin
            resume_q <= (resume_q & ~resume_clr) | (cfg_we & cfg_resume);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_IDLE;
            cda          <= '0;
            nda          <= '0;
            xfer         <= '0;
            eng_start    <= 1'b0;
            chain_done   <= 1'b0;
            fetch_go     <= 1'b0;
            fetch_base   <= '0;
            fetch_nwords <= '0;
        end else begin
            eng_start  <= 1'b0;
            chain_done <= 1'b0;
            fetch_go   <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start_wr) begin
                        nda <= align_desc(cfg_first_addr);
                        st  <= ST_CHECK;
                    end else if (resume_q) begin
                        fetch_go     <= 1'b1;
                        fetch_base   <= cda;
                        fetch_nwords <= CNT_W'(1);
                        st           <= ST_RELINK;
                    end
                end
                ST_CHECK: begin
                    if (nda != '0) begin
                        cda          <= nda;
                        fetch_go     <= 1'b1;
                        fetch_base   <= nda;
                        fetch_nwords <= CNT_W'(DESC_WORDS);
                        st           <= ST_FETCH;
                    end else begin
                        chain_done <= 1'b1;
                        st         <= ST_IDLE;
                    end
                end
                ST_FETCH: begin
                    if (fetch_done) begin
                        nda       <= align_desc(fetch_words[LINK_IDX]);
                        xfer.src  <= fetch_words[SRC_IDX];
                        xfer.dst  <= fetch_words[DST_IDX];
                        xfer.len  <= fetch_words[LEN_IDX];
                        eng_start <= 1'b1;
                        st        <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (eng_done) begin
                        if (nda != '0) begin
                            st <= ST_CHECK;
                        end else if (resume_q) begin
                            fetch_go     <= 1'b1;
                            fetch_base   <= cda;
                            fetch_nwords <= CNT_W'(1);
                            st           <= ST_RELINK;
                        end else begin
                            chain_done <= 1'b1;
                            st         <= ST_IDLE;
                        end
                    end
                end
                ST_RELINK: begin
                    if (fetch_done) begin
                        nda <= align_desc(fetch_words[LINK_IDX]);
                        st  <= ST_CHECK;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (st != ST_IDLE);
    assign cur_addr = cda;

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
    import dcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_start,
    input  logic              cfg_resume,
    input  logic [ADDR_W-1:0] cfg_first_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              eng_start,
    output logic [DATA_W-1:0] eng_src,
    output logic [DATA_W-1:0] eng_dst,
    output logic [DATA_W-1:0] eng_len,
    input  logic              eng_done,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              chain_done
);
    logic              fetch_go;
    logic [ADDR_W-1:0] fetch_base;
    logic [CNT_W-1:0]  fetch_nwords;
    logic              fetch_done;
    desc_words_t       fetch_words;
    xfer_t             xfer;

    dcs_fetch #(
        .NW (DESC_WORDS),
        .CW (CNT_W)
    ) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .go         (fetch_go),
        .base       (fetch_base),
        .nwords     (fetch_nwords),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .words      (fetch_words),
        .done       (fetch_done)
    );

    dcs_ctrl u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .cfg_we         (cfg_we),
        .cfg_start      (cfg_start),
        .cfg_resume     (cfg_resume),
        .cfg_first_addr (cfg_first_addr),
        .fetch_go       (fetch_go),
        .fetch_base     (fetch_base),
        .fetch_nwords   (fetch_nwords),
        .fetch_done     (fetch_done),
        .fetch_words    (fetch_words),
        .eng_start      (eng_start),
        .xfer           (xfer),
        .eng_done       (eng_done),
        .busy           (busy),
        .cur_addr       (cur_addr),
        .chain_done     (chain_done)
    );

    assign eng_src = xfer.src;
    assign eng_dst = xfer.dst;
    assign eng_len = xfer.len;

endmodule

// File: rtl/dcs_checker.sv
module dcs_checker
    import dcs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              eng_start,
    input logic [DATA_W-1:0] eng_src,
    input logic [DATA_W-1:0] eng_dst,
    input logic [DATA_W-1:0] eng_len,
    input logic              eng_done,
    input logic              busy,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              chain_done
);
    logic running;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
        end else if (eng_start) begin
            running <= 1'b1;
        end else if (eng_done) begin
            running <= 1'b0;
        end
    end

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req); // R2

    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy); // R2

    AST_DESC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (cur_addr & ADDR_W'((1 << ALIGN_BITS) - 1)) == '0); // R2

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start); // R3

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> busy); // R3

    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (rst)
        (running && !eng_start) |-> ($stable(eng_src) && $stable(eng_dst) && $stable(eng_len))); // R3

    AST_DONE_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> chain_done); // R5

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        chain_done |-> !busy); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        chain_done |=> !chain_done); // R5

endmodule

bind dma_chain_seq dcs_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_req    (mem_req),
    .eng_start  (eng_start),
    .eng_src    (eng_src),
    .eng_dst    (eng_dst),
    .eng_len    (eng_len),
    .eng_done   (eng_done),
    .busy       (busy),
    .cur_addr   (cur_addr),
    .chain_done (chain_done)
);

// File: tb/sim_dma_chain_seq.sv
module sim_dma_chain_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ENG_LAT    = 8;
    localparam int WD_LIMIT   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_start = 1'b0;
    logic        cfg_resume = 1'b0;
    logic [31:0] cfg_first_addr = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        eng_start;
    logic [31:0] eng_src, eng_dst, eng_len;
    logic        eng_done = 1'b0;
    logic        busy;
    logic [31:0] cur_addr;
    logic        chain_done;

    dma_chain_seq u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_start(cfg_start),
        .cfg_resume(cfg_resume), .cfg_first_addr(cfg_first_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .eng_start(eng_start), .eng_src(eng_src),
        .eng_dst(eng_dst), .eng_len(eng_len), .eng_done(eng_done),
        .busy(busy), .cur_addr(cur_addr), .chain_done(chain_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [31:0] mem [0:255];
    logic [31:0] exp_rd[$];
    string       exp_rd_tag[$];
    logic [31:0] exp_xa[$], exp_xs[$], exp_xd[$], exp_xl[$];

    int rd_ptr = 0, x_ptr = 0, done_cnt = 0;
    int mon_chk = 0, mon_err = 0;
    int chk_n = 0, err_n = 0;
    int cycles = 0;
    int rd_seq = 0;
    int lat_cnt = 0;
    int eng_timer = 0;
    bit rd_pend = 0;
    bit prev_done = 0;
    logic [31:0] rd_addr_q = '0;

    // Memory model, engine model and per-clock comparison against the expected queues
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        eng_done   = 1'b0;
        if (!rst) begin
            if (rd_pend) begin
                if (lat_cnt == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem[rd_addr_q[9:2]];
                    rd_pend    = 0;
                end else begin
                    lat_cnt--;
                end
            end
            if (mem_req) begin
                mon_chk++;
                if (rd_ptr >= exp_rd.size()) begin
                    mon_err++;
                    $display("FAIL R8: unexpected read actual %h expected none", mem_addr);
                end else if (mem_addr != exp_rd[rd_ptr]) begin
                    mon_err++;
                    $display("FAIL %s: read address actual %h expected %h",
                             exp_rd_tag[rd_ptr], mem_addr, exp_rd[rd_ptr]);
                end
                if (!busy) begin
                    mon_err++;
                    $display("FAIL R2: read while idle actual busy=%0d expected 1", busy);
                end
                rd_ptr++;
                rd_pend   = 1;
                rd_addr_q = mem_addr;
                lat_cnt   = rd_seq % 3;
                rd_seq++;
            end
            if (eng_timer > 0) begin
                eng_timer--;
                if (eng_timer == 0) eng_done = 1'b1;
            end
            if (eng_start) begin
                mon_chk++;
                if (x_ptr >= exp_xa.size()) begin
                    mon_err++;
                    $display("FAIL R3: unexpected eng_start actual %h expected none", cur_addr);
                end else if (cur_addr != exp_xa[x_ptr] || eng_src != exp_xs[x_ptr] ||
                             eng_dst != exp_xd[x_ptr] || eng_len != exp_xl[x_ptr]) begin
                    mon_err++;
                    $display("FAIL R3: transfer actual %h/%h/%h/%h expected %h/%h/%h/%h",
                             cur_addr, eng_src, eng_dst, eng_len,
                             exp_xa[x_ptr], exp_xs[x_ptr], exp_xd[x_ptr], exp_xl[x_ptr]);
                end
                x_ptr++;
                eng_timer = ENG_LAT;
            end
            if (chain_done) begin
                done_cnt++;
                mon_chk++;
                if (busy || prev_done) begin
                    mon_err++;
                    $display("FAIL R5: chain_done with busy/previous actual %0d/%0d expected 0/0",
                             busy, prev_done);
                end
            end
            prev_done = chain_done;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == WD_LIMIT) begin
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors",
                     chk_n + mon_chk + 1, err_n + mon_err + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        chk_n++;
        if (!ok) begin
            err_n++;
            $display("FAIL %s: %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] link,
                            input logic [31:0] src, input logic [31:0] dst,
                            input logic [31:0] len);
        mem[a[9:2]]        = link;
        mem[a[9:2] + 8'd1] = src;
        mem[a[9:2] + 8'd2] = dst;
        mem[a[9:2] + 8'd3] = len;
    endtask

    task automatic expect_desc(input logic [31:0] a, input string tag);
        for (int i = 0; i < 4; i++) begin
            exp_rd.push_back(a + 32'(4 * i));
            exp_rd_tag.push_back(tag);
        end
        exp_xa.push_back(a);
        exp_xs.push_back(mem[a[9:2] + 8'd1]);
        exp_xd.push_back(mem[a[9:2] + 8'd2]);
        exp_xl.push_back(mem[a[9:2] + 8'd3]);
    endtask

    task automatic expect_relink(input logic [31:0] a, input string tag);
        exp_rd.push_back(a);
        exp_rd_tag.push_back(tag);
    endtask

    task automatic walk(input logic [31:0] a, input string tag);
        logic [31:0] p;
        p = a & 32'hFFFF_FFF0;
        while (p != 0) begin
            expect_desc(p, tag);
            p = mem[p[9:2]] & 32'hFFFF_FFF0;
        end
    endtask

    task automatic cfg(input logic s, input logic r, input logic [31:0] a);
        cfg_we = 1'b1; cfg_start = s; cfg_resume = r; cfg_first_addr = a;
        @(negedge clk);
        cfg_we = 1'b0; cfg_start = 1'b0; cfg_resume = 1'b0;
    endtask

    task automatic scn_end(input int exp_done, input logic [31:0] exp_cur, input string tag);
        while (done_cnt < exp_done) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(rd_ptr == exp_rd.size(), tag, "reads issued", 32'(rd_ptr), 32'(exp_rd.size()));
        chk(x_ptr == exp_xa.size(), tag, "transfers run", 32'(x_ptr), 32'(exp_xa.size()));
        chk(done_cnt == exp_done, "R5", "chain_done count", 32'(done_cnt), 32'(exp_done));
        chk(busy == 1'b0, "R5", "busy after chain", 32'(busy), 32'd0);
        chk(cur_addr == exp_cur, tag, "cur_addr kept", cur_addr, exp_cur);
    endtask

    initial begin
        int xb;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy", 32'(busy), 32'd0);
        chk(cur_addr == 32'd0, "R1", "cur_addr", cur_addr, 32'd0);
        chk(mem_req == 1'b0 && eng_start == 1'b0 && chain_done == 1'b0, "R1",
            "req/start/done", {29'd0, mem_req, eng_start, chain_done}, 32'd0);

        // R2 R3 R4: three-descriptor chain, unaligned start and link
        put_desc(32'h040, 32'h087, 32'h1000, 32'h2000, 32'd64);
        put_desc(32'h080, 32'h0C0, 32'h1100, 32'h2100, 32'd128);
        put_desc(32'h0C0, 32'h000, 32'h1200, 32'h2200, 32'd12);
        walk(32'h040, "R4");
        cfg(1'b1, 1'b0, 32'h045);
        scn_end(1, 32'h0C0, "R4");

        // R7: resume while idle, tail patched to a new descriptor
        put_desc(32'h100, 32'h000, 32'h1300, 32'h2300, 32'd4);
        mem[32'h0C0 >> 2] = 32'h100;
        expect_relink(32'h0C0, "R7");
        walk(32'h100, "R7");
        cfg(1'b0, 1'b1, 32'h0);
        scn_end(2, 32'h100, "R7");

        // R7: resume while idle with the tail link still zero
        expect_relink(32'h100, "R7");
        cfg(1'b0, 1'b1, 32'h0);
        scn_end(3, 32'h100, "R7");

        // R6: append while the final descriptor runs
        put_desc(32'h140, 32'h180, 32'h1400, 32'h2400, 32'd8);
        put_desc(32'h180, 32'h000, 32'h1500, 32'h2500, 32'd16);
        xb = exp_xa.size();
        walk(32'h140, "R6");
        expect_relink(32'h180, "R6");
        put_desc(32'h1C0, 32'h000, 32'h1600, 32'h2600, 32'd20);
        expect_desc(32'h1C0, "R6");
        cfg(1'b1, 1'b0, 32'h140);
        while (x_ptr < xb + 2) @(negedge clk);
        mem[32'h180 >> 2] = 32'h1C0;
        cfg(1'b0, 1'b1, 32'h0);
        scn_end(4, 32'h1C0, "R6");

        // R8 R9: resume during a non-final descriptor, start while busy
        put_desc(32'h200, 32'h240, 32'h1700, 32'h2700, 32'd24);
        put_desc(32'h240, 32'h000, 32'h1800, 32'h2800, 32'd28);
        put_desc(32'h300, 32'h000, 32'h1900, 32'h2900, 32'd32);
        xb = exp_xa.size();
        walk(32'h200, "R8");
        cfg(1'b1, 1'b0, 32'h200);
        while (x_ptr < xb + 1) @(negedge clk);
        cfg(1'b0, 1'b1, 32'h0);
        chk(busy == 1'b1, "R9", "busy before start write", 32'(busy), 32'd1);
        cfg(1'b1, 1'b0, 32'h300);
        scn_end(5, 32'h240, "R9");

        // R10: start with an address that aligns to zero
        cfg(1'b1, 1'b0, 32'h00C);
        scn_end(6, 32'h240, "R10");

        $display("Simulation finished: %0d checks, %0d errors", chk_n + mon_chk, err_n + mon_err);
        $finish;
    end

endmodule